// File: doc/BRIEF.md
# Signed Array Multiplier with Folded Sign Correction

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product. The sign bits are not handled by subtraction. Each partial-product bit is still a single AND of one multiplicand bit and one multiplier bit. The products that pair exactly one sign bit with an ordinary bit are inverted, and two constant ones are placed in the matrix. Every entry of the matrix then carries positive weight. A chain of carry-save full-adder rows reduces the matrix to a sum vector and a carry vector, and a ripple-carry row resolves those two vectors into the product.

The parameter `PIPE` controls an optional register stage between the carry-save reduction and the ripple row. With `PIPE=1` the block accepts one operand pair per clock. The product and its valid flag appear one cycle after the operands. With `PIPE=0` the path from operands to product is purely combinational and the valid flag passes straight through.

Top module: `bw_mult`

## Requirements
- R1: With `valid_i` high, the product `p_o` equals the signed product of `a_i` and `b_i` taken modulo 2^(2N), for every pair of operands.
- R2: The most negative operand times itself (for N=4, -8 × -8) gives +2^(2N-2), which is 64 for N=4, with the top bit clear.
- R3: In the partial-product matrix, each bit that pairs exactly one sign bit is inverted, and constant ones are added at weights 2^N and 2^(2N-1). The matrix rows then sum to the signed product modulo 2^(2N), so operands of mixed sign give correct negative results.
- R4: Each carry-save row keeps its total: the sum vector plus the carry vector, shifted left by one, equals the sum of the row's three inputs modulo 2^(2N). Operand pairs that set many carries still resolve correctly.
- R5: With `PIPE=1`, a pair presented with `valid_i` high in one cycle appears on `p_o`, with `valid_o` high, in the next cycle.
- R6: With `PIPE=1`, `valid_o` is low in the cycle after any cycle in which `valid_i` is low, whatever the operand values are.
- R7: While `rst_ni` is low, `valid_o` is 0 and `p_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional register stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair is valid |
| a_i | input | N | Multiplicand, two's complement |
| b_i | input | N | Multiplier, two's complement |
| valid_o | output | 1 | Product is valid |
| p_o | output | 2N | Signed product |

## Verification
The bench builds the block with N=4 and PIPE=1. With N=4, all 256 operand pairs can be applied in turn. That covers every placement of the inverted sign-pair bits, both constant ones and the -8 × -8 corner. Having the register stage on brings the one-cycle latency, the reset state and the handling of idle cycles within reach. A behavioural model predicts the outputs for the next clock and compares them on every cycle.

// File: rtl/bw_pkg.sv
package bw_pkg;
  // true when exactly one index is the sign position
  function automatic bit sign_pair(input int i, input int j, input int n);
    return (i == n - 1) != (j == n - 1);
  endfunction
endpackage

// File: rtl/bw_pp_matrix.sv
module bw_pp_matrix
  import bw_pkg::*;
#(
  parameter int N = 4,
  localparam int PW = 2 * N
) (
  input  logic [N-1:0]         a_i,
  input  logic [N-1:0]         b_i,
  output logic [N:0][PW-1:0]   rows_o
);
  always_comb begin
    for (int j = 0; j < N; j++) begin
      rows_o[j] = '0;
      for (int i = 0; i < N; i++) begin
        rows_o[j][i+j] = sign_pair(i, j, N) ? ~(a_i[i] & b_i[j]) : (a_i[i] & b_i[j]);
      end
    end
    rows_o[N] = '0;
    rows_o[N][N] = 1'b1;
    rows_o[N][PW-1] = 1'b1;
  end

  logic signed [PW-1:0] a_ext, b_ext;
  assign a_ext = PW'($signed(a_i));
  assign b_ext = PW'($signed(b_i));

  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int k = 0; k <= N; k++) acc = acc + rows_o[k];
    AST_MATRIX_SUM: assert (acc == PW'(a_ext * b_ext)); // R3
  end
endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  assign c_o[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_fa
    assign s_o[k] = x_i[k] ^ y_i[k] ^ z_i[k];
    if (k < W - 1) begin : g_cy
      assign c_o[k+1] = (x_i[k] & y_i[k]) | (x_i[k] & z_i[k]) | (y_i[k] & z_i[k]);
    end
  end

  always_comb begin
    AST_CSA_CONSERVE: assert (W'(s_o + c_o) == W'(x_i + y_i + z_i)); // R4
  end
endmodule

// File: rtl/bw_ripple_add.sv
module bw_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign s_o[k] = x_i[k] ^ y_i[k] ^ cy[k];
    if (k < W - 1) begin : g_cy
      assign cy[k+1] = (x_i[k] & y_i[k]) | (cy[k] & (x_i[k] ^ y_i[k]));
    end
  end
endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int N    = 4,
  parameter bit PIPE = 1'b1,
  localparam int PW  = 2 * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [N-1:0]  a_i,
  input  logic [N-1:0]  b_i,
  output logic          valid_o,
  output logic [PW-1:0] p_o
);
  logic [N:0][PW-1:0] rows;

  bw_pp_matrix #(.N(N)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .rows_o(rows)
  );

  // carry-save chain: stage k folds in row k+1
  logic [N-1:0][PW-1:0] acc_s, acc_c;
  assign acc_s[0] = rows[0];
  assign acc_c[0] = rows[1];

  for (genvar k = 1; k < N; k++) begin : g_red
    bw_csa_row #(.W(PW)) u_csa (
      .x_i(acc_s[k-1]),
      .y_i(acc_c[k-1]),
      .z_i(rows[k+1]),
      .s_o(acc_s[k]),
      .c_o(acc_c[k])
    );
  end

  logic [PW-1:0] fin_s, fin_c;

  if (PIPE) begin : g_pipe
    logic [PW-1:0] s_q, c_q;
    logic          v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= '0;
        c_q <= '0;
        v_q <= 1'b0;
      end else begin
        s_q <= acc_s[N-1];
        c_q <= acc_c[N-1];
        v_q <= valid_i;
      end
    end
    assign fin_s   = s_q;
    assign fin_c   = c_q;
    assign valid_o = v_q;

    logic signed [PW-1:0] a_ext, b_ext;
    assign a_ext = PW'($signed(a_i));
    assign b_ext = PW'($signed(b_i));

    AST_PROD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> $signed(p_o) == $past(a_ext * b_ext)); // R1
    AST_CORNER_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && a_i == {1'b1, {(N-1){1'b0}}} && b_i == {1'b1, {(N-1){1'b0}}})
      |=> p_o == PW'(1) << (PW - 2)); // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R5
    AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R6
    AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> (!valid_o && p_o == '0)); // R7
  end else begin : g_comb
    assign fin_s   = acc_s[N-1];
    assign fin_c   = acc_c[N-1];
    assign valid_o = valid_i;
  end

  bw_ripple_add #(.W(PW)) u_cpa (
    .x_i(fin_s),
    .y_i(fin_c),
    .s_o(p_o)
  );
endmodule

// File: tb/bw_mult_test.sv
`timescale 1ns/1ps
module bw_mult_test;
  localparam int N  = 4;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_in = 1'b0;
  logic [N-1:0]  a = '0, b = '0;
  logic          valid_out;
  logic [PW-1:0] prod;

  always #2.5 clk = ~clk;

  bw_mult #(.N(N), .PIPE(1'b1)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .valid_i(valid_in),
    .a_i    (a),
    .b_i    (b),
    .valid_o(valid_out),
    .p_o    (prod)
  );

  int total = 0, bad = 0;
  logic          exp_v = 1'b0;
  logic [PW-1:0] exp_p = '0;
  string         exp_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] model(input logic [N-1:0] x, input logic [N-1:0] y);
    int sx, sy;
    sx = (x >= (1 << (N - 1))) ? int'(x) - (1 << N) : int'(x);
    sy = (y >= (1 << (N - 1))) ? int'(y) - (1 << N) : int'(y);
    return PW'(sx * sy);
  endfunction

  task automatic step(input logic v, input logic [N-1:0] x, input logic [N-1:0] y, input string req);
    @(negedge clk);
    chk(valid_out == exp_v, exp_v ? "R5" : "R6", int'(valid_out), int'(exp_v));
    if (exp_v) chk(prod == exp_p, exp_req, int'(prod), int'(exp_p));
    valid_in = v;
    a = x;
    b = y;
    exp_v = v;
    exp_p = model(x, y);
    exp_req = req;
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_out == 1'b0, "R7", int'(valid_out), 0);
    chk(prod == '0, "R7", int'(prod), 0);
    rst_n = 1'b1;

    // idle cycles with live operands must not raise valid
    step(1'b0, 4'h5, 4'h3, "R6");
    step(1'b0, 4'h8, 4'h8, "R6");
    step(1'b0, 4'h7, 4'h9, "R6");

    // exhaustive sweep, a gap inserted now and then
    for (int ia = 0; ia < (1 << N); ia++) begin
      for (int ib = 0; ib < (1 << N); ib++) begin
        string tag;
        logic [N-1:0] xa, xb;
        xa = N'(ia);
        xb = N'(ib);
        if (xa == 4'h8 && xb == 4'h8) tag = "R2";
        else if (xa[N-1] != xb[N-1]) tag = "R3";
        else if (xa == 4'h7 || xa == 4'hF) tag = "R4";
        else tag = "R1";
        step(1'b1, xa, xb, tag);
        if (((ia * 16 + ib) % 37) == 36) step(1'b0, ~xa, xb, "R6");
      end
    end

    // explicit corner cases back to back
    step(1'b1, 4'h8, 4'h8, "R2");
    step(1'b1, 4'h8, 4'h7, "R3");
    step(1'b1, 4'h7, 4'h7, "R4");
    step(1'b1, 4'hF, 4'hF, "R4");
    step(1'b0, 4'h0, 4'h0, "R6");
    step(1'b0, 4'h0, 4'h0, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule